// File: doc/BRIEF.md
# Accumulator datapath with flags

This block is the data path of a small signed accumulator machine. A controller decodes each instruction into a 5-bit opcode and an operand, and then pulses a step strobe for one clock cycle to commit it. Every arithmetic, logic, shift and load result goes into the accumulator. The block holds one general register, which software can read only by running an ALU operation on it. A sticky select decides whether the first ALU input, and the memory address of the direct load and store, come from the instruction operand or from that register. The block keeps a zero flag and an overflow flag, which the controller uses for its branch decisions.

The block drives a data-memory port: an address, write data and a write strobe. It reads the returned word combinationally during the same cycle. The controller paces the block one instruction per step pulse, so there is no valid/ready pair. A step pulse is always accepted in the cycle it is presented, and the block never applies back-pressure. The memory must return read data within that cycle and must accept a write on the edge that ends it. The data width is a parameter and is 8 by default. All data are treated as two's-complement values.

Top module: `accu_datapath`

## Requirements
- R1: After reset the accumulator, register, operand select, zero flag and overflow flag are all 0. While step_i is low, no state changes and mem_we_o stays 0, whatever the opcode.
- R2: ADD (00000) gives acc+op, SUB (00001) gives acc-op, INC (00010) gives acc+1, DEC (00011) gives acc-1 and NEG (01100) gives ~acc+1. All results wrap modulo 2^W, and none of these uses a carry-in. The overflow flag is set exactly when the signed result does not fit in W bits.
- R3: SLL (00100) shifts left and fills with 0. SRL (00101) shifts right and fills with 0. SRA (00111) shifts right and copies the sign bit. SLA (00110) shifts left and sets overflow when the sign bit changes. SLL, SRL and SRA clear overflow.
- R4: AND (01000), OR (01001) and XOR (01010) combine the first input with the accumulator. INV (01011) complements the accumulator. LOADN (01101) copies the first input into the accumulator. All five clear overflow.
- R5: After every accumulator-writing instruction (opcodes 00000 to 01110, and 11010), the zero flag equals (accumulator == 0).
- R6: MUXR (11000) makes the register the first ALU input and the direct memory address. This choice lasts until MUXOP (11001) restores the operand. The operand of MUXOP is ignored.
- R7: SETR (10100) copies the accumulator into the register and CLRR (10101) clears the register. Neither instruction changes the accumulator.
- R8: LOADV (01110) loads memory at the selected first input into the accumulator. STORE (01111) writes the accumulator there. mem_we_o is 1 only during a step of STORE or STOREA.
- R9: LOADA (11010) loads memory at the address held in the accumulator. STOREA (11011) writes the register to the address held in the accumulator, and the accumulator keeps its value.
- R10: SETF (10110) sets and CLRF (10111) clears a flag chosen by the operand: 0 selects zero and 1 selects overflow. Any other operand changes nothing. A flag forced this way holds until the next accumulator-writing instruction.
- R11: Controller-only opcodes leave the accumulator, the register and both flags unchanged. These are 10000 to 10011, HALT 11100 and NOP 11101 to 11111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Commit the presented instruction on this edge |
| opcode_i | input | 5 | Decoded opcode |
| operand_i | input | W | Instruction operand |
| mem_rdata_i | input | W | Data-memory read data, valid in the same cycle |
| mem_addr_o | output | W | Data-memory address |
| mem_wdata_o | output | W | Data-memory write data |
| mem_we_o | output | 1 | Data-memory write strobe |
| acc_o | output | W | Accumulator value |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench builds the block with its default width of 8 and models a 256-word memory that spans the whole address range. At this width both signed extremes, 0x7F and 0x80, can be reached with one LOADN each. Every overflow boundary of ADD, INC, DEC, NEG and SLA is therefore exercised directly, as are both sign cases of the shifts. The same width lets the register-selected and accumulator-held addresses reach any memory word, so the direct and indirect transfers are checked against words the bench itself has stored.

// File: rtl/accu_pkg.sv
package accu_pkg;

  typedef enum logic [4:0] {
    OP_ADD    = 5'b00000,
    OP_SUB    = 5'b00001,
    OP_INC    = 5'b00010,
    OP_DEC    = 5'b00011,
    OP_SLL    = 5'b00100,
    OP_SRL    = 5'b00101,
    OP_SLA    = 5'b00110,
    OP_SRA    = 5'b00111,
    OP_AND    = 5'b01000,
    OP_OR     = 5'b01001,
    OP_XOR    = 5'b01010,
    OP_INV    = 5'b01011,
    OP_NEG    = 5'b01100,
    OP_LOADN  = 5'b01101,
    OP_LOADV  = 5'b01110,
    OP_STORE  = 5'b01111,
    OP_JMP    = 5'b10000,
    OP_BIZ    = 5'b10001,
    OP_BINE   = 5'b10010,
    OP_BIOF   = 5'b10011,
    OP_SETR   = 5'b10100,
    OP_CLRR   = 5'b10101,
    OP_SETF   = 5'b10110,
    OP_CLRF   = 5'b10111,
    OP_MUXR   = 5'b11000,
    OP_MUXOP  = 5'b11001,
    OP_LOADA  = 5'b11010,
    OP_STOREA = 5'b11011,
    OP_HALT   = 5'b11100,
    OP_NOP    = 5'b11101,
    OP_NOP_B  = 5'b11110,
    OP_NOP_C  = 5'b11111
  } op_e;

  // True for every instruction whose result lands in the accumulator.
  function automatic logic writes_acc(logic [4:0] op);
    return (op <= OP_LOADV) || (op == OP_LOADA);
  endfunction

endpackage

// File: rtl/accu_alu.sv
module accu_alu
  import accu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] rdata_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o,
  output logic         load_o
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic sa, sacc;
  assign sa   = a_i[W-1];
  assign sacc = acc_i[W-1];

  always_comb begin
    res_o  = acc_i;
    ovf_o  = 1'b0;
    load_o = 1'b1;
    case (op_i)
      OP_ADD: begin
        res_o = acc_i + a_i;
        ovf_o = (sacc == sa) && (res_o[W-1] != sacc);
      end
      OP_SUB: begin
        res_o = acc_i - a_i;
        ovf_o = (sacc != sa) && (res_o[W-1] != sacc);
      end
      OP_INC: begin
        res_o = acc_i + W'(1);
        ovf_o = (acc_i == SMAX);
      end
      OP_DEC: begin
        res_o = acc_i - W'(1);
        ovf_o = (acc_i == SMIN);
      end
      OP_SLL:  res_o = {acc_i[W-2:0], 1'b0};
      OP_SRL:  res_o = {1'b0, acc_i[W-1:1]};
      OP_SLA: begin
        res_o = {acc_i[W-2:0], 1'b0};
        ovf_o = acc_i[W-1] ^ acc_i[W-2];
      end
      OP_SRA:  res_o = {acc_i[W-1], acc_i[W-1:1]};
      OP_AND:  res_o = acc_i & a_i;
      OP_OR:   res_o = acc_i | a_i;
      OP_XOR:  res_o = acc_i ^ a_i;
      OP_INV:  res_o = ~acc_i;
      OP_NEG: begin
        res_o = ~acc_i + W'(1);
        ovf_o = (acc_i == SMIN);
      end
      OP_LOADN: res_o = a_i;
      OP_LOADV, OP_LOADA: res_o = rdata_i;
      default: load_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/accu_opsel.sv
module accu_opsel
  import accu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] operand_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] reg_o
);

  logic         sel_q;
  logic [W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      reg_q <= '0;
    end else if (step_i) begin
      case (op_i)
        OP_MUXR:  sel_q <= 1'b1;
        OP_MUXOP: sel_q <= 1'b0;
        OP_SETR:  reg_q <= acc_i;
        OP_CLRR:  reg_q <= '0;
        default: ;
      endcase
    end
  end

  assign a_o   = sel_q ? reg_q : operand_i;
  assign reg_o = reg_q;

  p_sel_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i == OP_MUXR) |=> (a_o == reg_o));

  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i || (op_i != OP_MUXR && op_i != OP_MUXOP)) |=> $stable(sel_q));

  p_setr_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i == OP_SETR) |=> (reg_q == $past(acc_i)));

  p_clrr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i == OP_CLRR) |=> (reg_q == '0));

endmodule

// File: rtl/accu_flags.sv
module accu_flags
  import accu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] operand_i,
  input  logic         load_i,
  input  logic [W-1:0] res_i,
  input  logic         ovf_i,
  output logic         zero_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] SEL_ZERO = W'(0);
  localparam logic [W-1:0] SEL_OVF  = W'(1);

  logic force_op, force_val;
  assign force_op  = (op_i == OP_SETF) || (op_i == OP_CLRF);
  assign force_val = (op_i == OP_SETF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else if (step_i) begin
      if (load_i) begin
        zero_o <= (res_i == '0);
        ovf_o  <= ovf_i;
      end else if (force_op) begin
        if (operand_i == SEL_ZERO)     zero_o <= force_val;
        else if (operand_i == SEL_OVF) ovf_o  <= force_val;
      end
    end
  end

  p_setf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i == OP_SETF && operand_i == SEL_ZERO) |=> zero_o);

  p_clrf_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i == OP_CLRF && operand_i == SEL_OVF) |=> !ovf_o);

  p_flag_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && force_op && operand_i != SEL_ZERO && operand_i != SEL_OVF)
      |=> ($stable(zero_o) && $stable(ovf_o)));

  p_nondata_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !writes_acc(op_i) && !force_op) |=> ($stable(zero_o) && $stable(ovf_o)));

endmodule

// File: rtl/accu_datapath.sv
module accu_datapath
  import accu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic [4:0]   opcode_i,
  input  logic [W-1:0] operand_i,
  input  logic [W-1:0] mem_rdata_i,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  output logic         mem_we_o,
  output logic [W-1:0] acc_o,
  output logic         zero_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] acc_q;
  logic [W-1:0] a_sel, reg_val, alu_res;
  logic         alu_ovf, alu_load;
  logic         use_acc_addr;

  accu_opsel #(.W(W)) u_opsel (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(opcode_i),
    .acc_i(acc_q), .operand_i(operand_i), .a_o(a_sel), .reg_o(reg_val)
  );

  accu_alu #(.W(W)) u_alu (
    .op_i(opcode_i), .a_i(a_sel), .acc_i(acc_q), .rdata_i(mem_rdata_i),
    .res_o(alu_res), .ovf_o(alu_ovf), .load_o(alu_load)
  );

  accu_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(opcode_i),
    .operand_i(operand_i), .load_i(alu_load), .res_i(alu_res),
    .ovf_i(alu_ovf), .zero_o(zero_o), .ovf_o(ovf_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   acc_q <= '0;
    else if (step_i && alu_load)  acc_q <= alu_res;
  end

  assign use_acc_addr = (opcode_i == OP_LOADA) || (opcode_i == OP_STOREA);
  assign mem_addr_o   = use_acc_addr ? acc_q : a_sel;
  assign mem_wdata_o  = (opcode_i == OP_STOREA) ? reg_val : acc_q;
  assign mem_we_o     = step_i && ((opcode_i == OP_STORE) || (opcode_i == OP_STOREA));
  assign acc_o        = acc_q;

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(acc_q) && $stable(zero_o) && $stable(ovf_o)));

  p_inc_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && opcode_i == OP_INC && acc_q == SMAX) |=> (ovf_o && acc_q == SMIN));

  p_zero_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && writes_acc(opcode_i)) |=> (zero_o == (acc_q == '0)));

  p_nondata_acc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !writes_acc(opcode_i)) |=> $stable(acc_q));

endmodule

// File: tb/test_accu_datapath.sv
`timescale 1ns/1ps
module test_accu_datapath;
  import accu_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0;
  logic [4:0] opcode = OP_NOP;
  logic [7:0] operand = '0;
  logic [7:0] mem_rdata, mem_addr, mem_wdata, acc;
  logic       mem_we, zero, ovf;
  logic [7:0] mem [256];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  accu_datapath #(.W(8)) i_accu_datapath (
    .clk(clk), .rst_n(rst_n), .step_i(step), .opcode_i(opcode),
    .operand_i(operand), .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .acc_o(acc),
    .zero_o(zero), .ovf_o(ovf)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic state(input string tag, input logic [7:0] a, input logic z, input logic o);
    check({tag, " acc"}, acc, a);
    check({tag, " zero"}, {7'd0, zero}, {7'd0, z});
    check({tag, " ovf"}, {7'd0, ovf}, {7'd0, o});
  endtask

  task automatic run_op(input logic [4:0] op, input logic [7:0] arg);
    @(negedge clk);
    opcode = op; operand = arg; step = 1'b1;
    @(negedge clk);
    step = 1'b0; opcode = OP_NOP;
  endtask

  task automatic t_reset();
    state("R1 reset", 8'h00, 1'b0, 1'b0);
    check("R1 reset we", {7'd0, mem_we}, 8'h00);
  endtask

  task automatic t_arith();
    run_op(OP_LOADN, 8'h7F); run_op(OP_ADD, 8'h01);
    state("R2 add overflow", 8'h80, 1'b0, 1'b1);
    run_op(OP_LOADN, 8'h05); run_op(OP_SUB, 8'h05);
    state("R2 R5 sub to zero", 8'h00, 1'b1, 1'b0);
    run_op(OP_SUB, 8'h01);
    state("R2 sub negative", 8'hFF, 1'b0, 1'b0);
    run_op(OP_LOADN, 8'h80); run_op(OP_SUB, 8'h01);
    state("R2 sub overflow", 8'h7F, 1'b0, 1'b1);
    run_op(OP_INC, 8'h00);
    state("R2 inc overflow", 8'h80, 1'b0, 1'b1);
    run_op(OP_DEC, 8'h00);
    state("R2 dec overflow", 8'h7F, 1'b0, 1'b1);
    run_op(OP_NEG, 8'h00);
    state("R2 neg", 8'h81, 1'b0, 1'b0);
    run_op(OP_LOADN, 8'h80); run_op(OP_NEG, 8'h00);
    state("R2 neg of min", 8'h80, 1'b0, 1'b1);
  endtask

  task automatic t_shift();
    run_op(OP_LOADN, 8'hC1); run_op(OP_SLL, 8'h00);
    state("R3 sll", 8'h82, 1'b0, 1'b0);
    run_op(OP_SRL, 8'h00);
    state("R3 srl", 8'h41, 1'b0, 1'b0);
    run_op(OP_LOADN, 8'h82); run_op(OP_SRA, 8'h00);
    state("R3 sra", 8'hC1, 1'b0, 1'b0);
    run_op(OP_LOADN, 8'h41); run_op(OP_SLA, 8'h00);
    state("R3 sla sign change", 8'h82, 1'b0, 1'b1);
    run_op(OP_SRL, 8'h00);
    state("R3 srl clears ovf", 8'h41, 1'b0, 1'b0);
    run_op(OP_LOADN, 8'hC1); run_op(OP_SLA, 8'h00);
    state("R3 sla keep sign", 8'h82, 1'b0, 1'b0);
  endtask

  task automatic t_logic();
    run_op(OP_LOADN, 8'h7F); run_op(OP_INC, 8'h00);
    run_op(OP_LOADN, 8'hF0);
    state("R4 loadn clears ovf", 8'hF0, 1'b0, 1'b0);
    run_op(OP_AND, 8'h3C); check("R4 and", acc, 8'h30);
    run_op(OP_OR, 8'h03);  check("R4 or", acc, 8'h33);
    run_op(OP_XOR, 8'hFF); check("R4 xor", acc, 8'hCC);
    run_op(OP_INV, 8'h00); check("R4 inv", acc, 8'h33);
    run_op(OP_AND, 8'h00);
    state("R4 R5 and to zero", 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_idle();
    run_op(OP_LOADN, 8'h21);
    @(negedge clk);
    opcode = OP_STORE; operand = 8'h10; step = 1'b0;
    #1 check("R1 idle no write", {7'd0, mem_we}, 8'h00);
    opcode = OP_INC;
    repeat (3) @(negedge clk);
    opcode = OP_NOP;
    state("R1 idle hold", 8'h21, 1'b0, 1'b0);
  endtask

  task automatic t_reg_mux();
    run_op(OP_LOADN, 8'h25); run_op(OP_SETR, 8'h00);
    check("R7 setr keeps acc", acc, 8'h25);
    run_op(OP_LOADN, 8'h00); run_op(OP_MUXR, 8'h00);
    run_op(OP_ADD, 8'h99);
    check("R6 R7 add uses register", acc, 8'h25);
    run_op(OP_LOADN, 8'h99);
    check("R6 loadn uses register", acc, 8'h25);
    run_op(OP_MUXOP, 8'h55);
    run_op(OP_LOADN, 8'h10);
    check("R6 muxop restores operand", acc, 8'h10);
    run_op(OP_CLRR, 8'h00);
    check("R7 clrr keeps acc", acc, 8'h10);
    run_op(OP_MUXR, 8'h00); run_op(OP_LOADN, 8'h44);
    check("R7 clrr cleared register", acc, 8'h00);
    run_op(OP_MUXOP, 8'h00);
  endtask

  task automatic t_mem();
    run_op(OP_LOADN, 8'h5A);
    @(negedge clk);
    opcode = OP_STORE; operand = 8'h20; step = 1'b1;
    #1;
    check("R8 store we", {7'd0, mem_we}, 8'h01);
    check("R8 store addr", mem_addr, 8'h20);
    check("R8 store data", mem_wdata, 8'h5A);
    @(negedge clk);
    step = 1'b0; opcode = OP_NOP;
    check("R8 memory written", mem[8'h20], 8'h5A);
    run_op(OP_LOADN, 8'h00); run_op(OP_STORE, 8'h30);
    run_op(OP_LOADN, 8'h05); run_op(OP_LOADV, 8'h20);
    state("R8 loadv", 8'h5A, 1'b0, 1'b0);
    run_op(OP_LOADV, 8'h30);
    state("R8 R5 loadv zero", 8'h00, 1'b1, 1'b0);
    run_op(OP_LOADN, 8'h20); run_op(OP_SETR, 8'h00);
    run_op(OP_LOADN, 8'h00); run_op(OP_MUXR, 8'h00);
    run_op(OP_LOADV, 8'hFF);
    check("R6 R8 loadv register address", acc, 8'h5A);
    run_op(OP_MUXOP, 8'h00);
  endtask

  task automatic t_indirect();
    run_op(OP_LOADN, 8'h77); run_op(OP_SETR, 8'h00);
    run_op(OP_LOADN, 8'h40); run_op(OP_STOREA, 8'h00);
    check("R9 storea writes register", mem[8'h40], 8'h77);
    check("R9 storea keeps acc", acc, 8'h40);
    run_op(OP_LOADA, 8'h00);
    check("R9 loada", acc, 8'h77);
  endtask

  task automatic t_flags();
    run_op(OP_LOADN, 8'h01);
    run_op(OP_SETF, 8'h00);
    state("R10 setf zero", 8'h01, 1'b1, 1'b0);
    run_op(OP_NOP, 8'h00);
    state("R10 forced zero holds", 8'h01, 1'b1, 1'b0);
    run_op(OP_SETF, 8'h01);
    state("R10 setf ovf", 8'h01, 1'b1, 1'b1);
    run_op(OP_CLRF, 8'h05);
    state("R10 other operand ignored", 8'h01, 1'b1, 1'b1);
    run_op(OP_CLRF, 8'h00);
    run_op(OP_STORE, 8'h50);
    state("R10 clrf zero holds", 8'h01, 1'b0, 1'b1);
    run_op(OP_CLRF, 8'h01);
    state("R10 clrf ovf", 8'h01, 1'b0, 1'b0);
    run_op(OP_SETF, 8'h01);
    run_op(OP_DEC, 8'h00);
    state("R10 data op recomputes", 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_nondata();
    logic [4:0] ops [8];
    ops = '{OP_JMP, OP_BIZ, OP_BINE, OP_BIOF, OP_HALT, OP_NOP, OP_NOP_B, OP_NOP_C};
    run_op(OP_LOADN, 8'h7F); run_op(OP_ADD, 8'h01);
    for (int k = 0; k < 8; k++) run_op(ops[k], 8'h03);
    state("R11 controller opcodes", 8'h80, 1'b0, 1'b1);
    run_op(OP_MUXR, 8'h00); run_op(OP_LOADN, 8'h00);
    check("R11 register unchanged", acc, 8'h77);
    run_op(OP_MUXOP, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_arith();
    t_shift();
    t_logic();
    t_idle();
    t_reg_mux();
    t_mem();
    t_indirect();
    t_flags();
    t_nondata();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule